// File: doc/BRIEF.md
# Video Register Command Decoder

The decoder takes a byte stream from a valid/ready source and turns register-write commands into updates of a 256-entry, 8-bit video register file. A command is four bytes: the start marker 0xAF, an opcode, a register address and a value. Only opcode 0x20 (single register write) acts on the registers. Any other opcode makes the decoder drop back and wait for the next start marker. A byte that arrives while the decoder waits for a start marker is thrown away and counted.

The register file has two banks. Register address 0xFF is a lock control and is not itself stored. Writing 0x00 to it locks the file. While the file is locked, writes change only the shadow bank. Writing 0xFF to it unlocks the file and copies the whole shadow bank into the active bank at one clock edge, so a full mode change takes effect all at once. While the file is unlocked, each write updates both banks. The display path reads the active bank through a combinational view port and through decoded outputs for colour depth, blank mode and the two 24-bit base addresses.

Top module: `vidreg_cmd_decoder`

## Requirements
- R1: While waiting for a start marker, an accepted byte other than 0xAF is discarded and `err_count` rises by one, saturating at all ones.
- R2: The sequence 0xAF, 0x20, address, value writes the value to that register. Any byte, 0xAF included, is taken as the address or the value when it falls in those positions. When the file is unlocked, the new value appears at `view_data` for that address after the clock edge that accepts the value byte.
- R3: An opcode byte other than 0x20 or 0xAF returns the decoder to waiting for a start marker, does not count as an error and writes nothing. `in_ready` is always 1.
- R4: A 0xAF received in the opcode position is treated as a fresh start marker, so a lone padding 0xAF does not corrupt the command that follows it.
- R5: Writing 0x00 to address 0xFF sets `lock_active`. While it is set, writes reach only the shadow bank, and every active output, `view_data` included, keeps its value.
- R6: Writing 0xFF to address 0xFF clears `lock_active` and copies every shadow register into the active bank at the same edge. `commit_pulse` is then high for exactly the following cycle. Any other value written to 0xFF has no effect.
- R7: `depth_24` is bit 0 of register 0x00: 0 selects 16 bpp and 1 selects 24 bpp.
- R8: `blank_mode` is the active register 0x1F: 0x00 means syncs on, 0x01 means blanked but powered, 0x07 means powered down.
- R9: `base16_addr` is {reg 0x20, reg 0x21, reg 0x22} and `base8_addr` is {reg 0x26, reg 0x27, reg 0x28}, with the lower address as the most significant byte.
- R10: After reset the file is unlocked, `blank_mode` is 0x07, every other register is 0x00, `err_count` is 0 and `commit_pulse` is 0.
- R11: A byte presented while `in_valid` is low has no effect on the registers, the decoder state or `err_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Always 1; the stream is never stalled |
| view_addr | input | 8 | Active-bank read address |
| view_data | output | 8 | Active-bank value at `view_addr` |
| depth_24 | output | 1 | Colour depth select, 1 = 24 bpp |
| blank_mode | output | 8 | Active blank-mode code |
| base16_addr | output | 24 | 16 bpp segment base |
| base8_addr | output | 24 | 8 bpp segment base |
| lock_active | output | 1 | Register file locked |
| commit_pulse | output | 1 | One-cycle strobe after an unlock commit |
| err_count | output | 8 | Saturating count of discarded idle bytes |

## Verification
The bench targets four cases:
- A padding 0xAF directly before a real command. A decoder that reads the second 0xAF as an unknown opcode would lose the command and count its opcode as an error.
- A value byte equal to 0xAF. A decoder that restarts on every marker would never store that value.
- A locked sequence followed by an unlock. Here the active outputs must not move until the commit edge, and then all of them must change together with a single `commit_pulse`.
- Idle junk bytes, unknown opcodes and bytes presented with `in_valid` low. Each of these shows up as a wrong `err_count`.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;
  localparam logic [7:0] START_BYTE  = 8'hAF;
  localparam logic [7:0] OP_REG_WR   = 8'h20;
  localparam logic [7:0] LOCK_ADDR   = 8'hFF;
  localparam logic [7:0] LOCK_ON     = 8'h00;
  localparam logic [7:0] LOCK_OFF    = 8'hFF;
  localparam logic [7:0] DEPTH_ADDR  = 8'h00;
  localparam logic [7:0] BLANK_ADDR  = 8'h1F;
  localparam logic [7:0] BLANK_RESET = 8'h07;
  localparam logic [7:0] B16_ADDR    = 8'h20;
  localparam logic [7:0] B8_ADDR     = 8'h26;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_OP   = 2'd1,
    PS_ADDR = 2'd2,
    PS_DATA = 2'd3
  } parse_state_t;

  function automatic logic is_start(input logic [7:0] b);
    return b == START_BYTE;
  endfunction

  function automatic logic [7:0] reg_reset_value(input int idx);
    return (idx == int'(BLANK_ADDR)) ? BLANK_RESET : 8'h00;
  endfunction

  function automatic logic [23:0] pack_base(input logic [7:0] hi,
                                            input logic [7:0] mid,
                                            input logic [7:0] lo);
    return {hi, mid, lo};
  endfunction
endpackage

// File: rtl/vidreg_parser.sv
module vidreg_parser
  import vidreg_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             wr_fire,
  output logic [7:0]       wr_addr,
  output logic [7:0]       wr_data,
  output logic             junk_byte,
  output logic [ERR_W-1:0] err_count
);
  parse_state_t state_q, state_d;
  logic [7:0]   addr_q;

  always_comb begin
    state_d   = state_q;
    junk_byte = 1'b0;
    wr_fire   = 1'b0;
    if (in_valid) begin
      unique case (state_q)
        PS_IDLE: begin
          if (is_start(in_data)) state_d = PS_OP;
          else junk_byte = 1'b1;
        end
        PS_OP: begin
          if (is_start(in_data))        state_d = PS_OP;
          else if (in_data == OP_REG_WR) state_d = PS_ADDR;
          else                           state_d = PS_IDLE;
        end
        PS_ADDR: state_d = PS_DATA;
        PS_DATA: begin
          wr_fire = 1'b1;
          state_d = PS_IDLE;
        end
        default: state_d = PS_IDLE;
      endcase
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= PS_IDLE;
      addr_q    <= 8'h00;
      err_count <= '0;
    end else begin
      state_q <= state_d;
      if (in_valid && state_q == PS_ADDR) addr_q <= in_data;
      if (junk_byte && err_count != {ERR_W{1'b1}}) err_count <= err_count + 1'b1;
    end
  end
endmodule

// File: rtl/vidreg_lock.sv
module vidreg_lock
  import vidreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       locked,
  output logic       commit_now,
  output logic       commit_pulse
);
  logic lock_hit;
  assign lock_hit   = wr_fire && (wr_addr == LOCK_ADDR);
  assign commit_now = lock_hit && (wr_data == LOCK_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked       <= 1'b0;
      commit_pulse <= 1'b0;
    end else begin
      commit_pulse <= commit_now;
      if (lock_hit && wr_data == LOCK_ON) locked <= 1'b1;
      else if (commit_now)                locked <= 1'b0;
    end
  end
endmodule

// File: rtl/vidreg_banks.sv
module vidreg_banks
  import vidreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              locked,
  input  logic              commit_now,
  output logic [7:0]        active [NUM_REGS]
);
  logic [7:0] shadow [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == int'(LOCK_ADDR)) begin : g_lock_slot
      assign shadow[i] = 8'h00;
      assign active[i] = 8'h00;
    end else begin : g_store
      logic hit;
      assign hit = wr_fire && (wr_addr == ADDR_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          shadow[i] <= reg_reset_value(i);
          active[i] <= reg_reset_value(i);
        end else begin
          if (hit) shadow[i] <= wr_data;
          if (commit_now)        active[i] <= shadow[i];
          else if (hit && !locked) active[i] <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/vidreg_cmd_decoder.sv
module vidreg_cmd_decoder
  import vidreg_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic [7:0]       view_addr,
  output logic [7:0]       view_data,
  output logic             depth_24,
  output logic [7:0]       blank_mode,
  output logic [23:0]      base16_addr,
  output logic [23:0]      base8_addr,
  output logic             lock_active,
  output logic             commit_pulse,
  output logic [ERR_W-1:0] err_count
);
  localparam int ADDR_W   = 8;
  localparam int NUM_REGS = 1 << ADDR_W;

  logic       wr_fire, junk_byte, commit_now;
  logic [7:0] wr_addr, wr_data;
  logic [7:0] active [NUM_REGS];

  assign in_ready = 1'b1;

  vidreg_parser #(.ERR_W(ERR_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .junk_byte(junk_byte), .err_count(err_count)
  );

  vidreg_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .locked(lock_active), .commit_now(commit_now),
    .commit_pulse(commit_pulse)
  );

  vidreg_banks #(.ADDR_W(ADDR_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .locked(lock_active), .commit_now(commit_now),
    .active(active)
  );

  assign view_data   = active[view_addr];
  assign depth_24    = active[DEPTH_ADDR][0];
  assign blank_mode  = active[BLANK_ADDR];
  assign base16_addr = pack_base(active[B16_ADDR], active[B16_ADDR + 8'd1],
                                 active[B16_ADDR + 8'd2]);
  assign base8_addr  = pack_base(active[B8_ADDR], active[B8_ADDR + 8'd1],
                                 active[B8_ADDR + 8'd2]);
endmodule

// File: rtl/vidreg_cmd_decoder_chk.sv
module vidreg_cmd_decoder_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             wr_fire,
  input logic [7:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             junk_byte,
  input logic [7:0]       blank_mode,
  input logic [23:0]      base16_addr,
  input logic             lock_active,
  input logic             commit_pulse,
  input logic [ERR_W-1:0] err_count
);
  // R3
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R6
  unlock_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == 8'hFF && wr_data == 8'hFF) |=> (commit_pulse && !lock_active));

  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> (commit_pulse || ($stable(blank_mode) && $stable(base16_addr))));

  // R11
  idle_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(err_count));

  // R1
  junk_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (junk_byte && err_count != {ERR_W{1'b1}}) |=> (err_count == $past(err_count) + 1'b1));

  // R2
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> in_valid);
endmodule

bind vidreg_cmd_decoder vidreg_cmd_decoder_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
  .junk_byte(junk_byte), .blank_mode(blank_mode), .base16_addr(base16_addr),
  .lock_active(lock_active), .commit_pulse(commit_pulse), .err_count(err_count)
);

// File: tb/sim_vidreg_cmd_decoder.sv
module sim_vidreg_cmd_decoder;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;
  // each entry: {address, value}, written while unlocked and read back (R2)
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0112, 16'h0234, 16'h17A5, 16'h1BC3,
    16'h0F80, 16'h2A5A, 16'h4011, 16'hFE01
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic [7:0]  view_addr = 8'h00;
  logic [7:0]  view_data;
  logic        depth_24;
  logic [7:0]  blank_mode;
  logic [23:0] base16_addr, base8_addr;
  logic        lock_active, commit_pulse;
  logic [7:0]  err_count;
  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  vidreg_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .view_addr(view_addr), .view_data(view_data),
    .depth_24(depth_24), .blank_mode(blank_mode), .base16_addr(base16_addr),
    .base8_addr(base8_addr), .lock_active(lock_active),
    .commit_pulse(commit_pulse), .err_count(err_count)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    put(8'hAF); put(8'h20); put(a); put(v);
    settle();
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
    view_addr = a;
    #1;
    check(tag, {24'h0, view_data}, {24'h0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    // R10 reset state
    check("R10 blank", {24'h0, blank_mode}, 32'h07);
    check("R10 depth", {31'h0, depth_24}, 32'h0);
    check("R10 base16", {8'h0, base16_addr}, 32'h0);
    check("R10 lock", {31'h0, lock_active}, 32'h0);
    check("R10 err", {24'h0, err_count}, 32'h0);
    check("R10 commit", {31'h0, commit_pulse}, 32'h0);
    check("R3 ready", {31'h0, in_ready}, 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][15:8], VEC[i][7:0]);
      peek(VEC[i][15:8], VEC[i][7:0], "R2 table write");
    end

    // R7 colour depth
    wr(8'h00, 8'h01);
    check("R7 depth 24", {31'h0, depth_24}, 32'h1);
    wr(8'h00, 8'h00);
    check("R7 depth 16", {31'h0, depth_24}, 32'h0);

    // R8 blank mode
    wr(8'h1F, 8'h01);
    check("R8 blank", {24'h0, blank_mode}, 32'h01);

    // R9 base addresses, lower register is the high byte
    wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
    check("R9 base16", {8'h0, base16_addr}, 32'h123456);
    wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
    check("R9 base8", {8'h0, base8_addr}, 32'hABCDEF);

    // R5 locked writes stay in the shadow bank
    wr(8'hFF, 8'h00);
    check("R5 lock set", {31'h0, lock_active}, 32'h1);
    wr(8'h1F, 8'h07);
    wr(8'h20, 8'h99);
    check("R5 blank held", {24'h0, blank_mode}, 32'h01);
    check("R5 base16 held", {8'h0, base16_addr}, 32'h123456);
    peek(8'h20, 8'h12, "R5 view held");

    // R6 other value to the lock register ignored
    wr(8'hFF, 8'h55);
    check("R6 odd lock value", {31'h0, lock_active}, 32'h1);
    check("R6 no commit", {31'h0, commit_pulse}, 32'h0);

    // R6 unlock commits everything at once
    wr(8'hFF, 8'hFF);
    check("R6 commit pulse", {31'h0, commit_pulse}, 32'h1);
    check("R6 unlocked", {31'h0, lock_active}, 32'h0);
    check("R6 blank commit", {24'h0, blank_mode}, 32'h07);
    check("R6 base16 commit", {8'h0, base16_addr}, 32'h993456);
    @(negedge clk);
    check("R6 pulse one cycle", {31'h0, commit_pulse}, 32'h0);

    // R1 junk bytes while idle
    put(8'h12); settle();
    check("R1 junk one", {24'h0, err_count}, 32'h1);
    put(8'h20); settle();
    check("R1 junk two", {24'h0, err_count}, 32'h2);

    // R3 unknown opcode skipped, next command intact
    put(8'hAF); put(8'h6A); settle();
    wr(8'h05, 8'h33);
    peek(8'h05, 8'h33, "R3 after unknown op");
    check("R3 no error", {24'h0, err_count}, 32'h2);

    // R4 padding start byte before a command
    put(8'hAF);
    wr(8'h06, 8'h44);
    peek(8'h06, 8'h44, "R4 padding");
    check("R4 no error", {24'h0, err_count}, 32'h2);

    // R2 value byte equal to the start marker
    wr(8'h07, 8'hAF);
    peek(8'h07, 8'hAF, "R2 value AF");

    // R11 bytes with valid low ignored
    @(negedge clk);
    in_data = 8'h12;
    repeat (3) @(negedge clk);
    in_data = 8'h00;
    check("R11 err unchanged", {24'h0, err_count}, 32'h2);
    peek(8'h07, 8'hAF, "R11 reg unchanged");

    // R10 reset again after activity
    do_reset();
    check("R10 blank again", {24'h0, blank_mode}, 32'h07);
    check("R10 err again", {24'h0, err_count}, 32'h0);
    peek(8'h20, 8'h00, "R10 reg cleared");

    summary();
  end
endmodule